// File: doc/BRIEF.md
# High-Resolution Edge PWM Core

This block produces a fixed-frequency pulse-width-modulated output whose falling edge can be placed with the precision of a single input clock. The input clock itself is the fine tick. A coarse loop is built from a power-of-two number of fine ticks (32, 64 or 128, set by a 2-bit prescaler code). A loop counter counts loops from zero up to a programmable maximum and then wraps, so a period lasts `(per_max + 1) * 2^P` clock cycles.

The duty position is given as two fields: a loop count, which picks the coarse slot, and a fine offset, which gives the position inside that slot in fine ticks. The output rises at the start of every period and falls at the cycle given by those two fields. A single-cycle strobe marks the first cycle of each new period. The prescaler code, period maximum and compare fields are taken in only when a period starts, so software may change them at any time without producing a runt pulse.

Top module: `hrpwm_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), `pwm_o` and `period_end_o` are low from the first clock edge on.
- R2: While enabled, each period lasts exactly `(per_max + 1) * 2^P` clock cycles. `period_end_o` is high only in the first cycle of each period that follows a wrap.
- R3: Prescaler code `pre_sel` selects 2^P fine ticks per loop: code 0 gives 32, code 1 gives 64, code 2 gives 128, and code 3 also gives 128.
- R4: In every period `pwm_o` is high from the first cycle for exactly `E = cmp_loop * 2^P + (cmp_fine mod 2^P)` cycles and low for the rest. The rising edge occurs only in the first cycle of a period.
- R5: A compare of zero (`cmp_loop = 0`, `cmp_fine = 0`) keeps `pwm_o` low for the whole period (0% duty).
- R6: With `cmp_loop > per_max`, which means a compare at or past the period length, `pwm_o` stays high for the whole period (100% duty).
- R7: Bits of `cmp_fine` at position P and above are ignored.
- R8: Values applied to `pre_sel`, `per_max`, `cmp_loop` and `cmp_fine` during a period have no effect on that period. They govern the period that follows the next wrap.
- R9: While `en` is low, `pwm_o` and `period_end_o` are low from the next cycle on. After the clock edge at which `en` is first sampled high, a period begins in the following cycle using the current inputs, and that first cycle carries no strobe.
- R10: `period_end_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the fine tick |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| pre_sel | input | 2 | Loop length code (0:32, 1:64, 2/3:128 ticks) |
| per_max | input | 8 | Last loop index of the period |
| cmp_loop | input | 8 | Coarse compare: loop holding the falling edge |
| cmp_fine | input | 7 | Fine compare: tick offset inside that loop |
| pwm_o | output | 1 | PWM output |
| period_end_o | output | 1 | One-cycle strobe in the first cycle of a new period |

## Verification
The period wrap, together with its strobe and configuration reload, can fall in the same cycle as the duty edge. Setting the fine compare to the last tick of the last loop makes the output drop on the final tick and rise again on the very next cycle, which is the cycle that carries the strobe. The bench provokes this and judges it by checking the measured period length and the measured high count against the values computed for that period. New settings are always applied one period ahead of the point where they take effect, so every reload happens on a wrap while the previous period's values are still being measured.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

    // Width of the loop counter, period maximum and coarse compare field.
    localparam int LOOP_W  = 8;
    // Width of the fine compare field; covers the longest loop (2^7 ticks).
    localparam int FINE_W  = 7;
    // Width of the prescaler code.
    localparam int SEL_W   = 2;
    // Shortest loop exponent, selected by code 0.
    localparam int SHIFT_MIN = 5;
    // Longest loop exponent; codes at or past this value saturate.
    localparam int SHIFT_MAX = 7;
    // Width of an absolute tick position inside a period.
    localparam int POS_W   = LOOP_W + FINE_W;

    typedef logic [LOOP_W-1:0] loop_t;
    typedef logic [FINE_W-1:0] fine_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        loop_t            per_max;
        loop_t            cmp_loop;
        fine_t            cmp_fine;
    } pwm_cfg_t;

    // Loop exponent P for a prescaler code.
    function automatic logic [2:0] sel_shift(input logic [SEL_W-1:0] sel);
        int s;
        s = SHIFT_MIN + int'(sel);
        if (s > SHIFT_MAX) s = SHIFT_MAX;
        return 3'(s);
    endfunction

    // Index of the last fine tick in a loop: 2^P - 1.
    function automatic fine_t fine_last(input logic [SEL_W-1:0] sel);
        logic [FINE_W:0] t;
        t = (FINE_W+1)'((FINE_W+1)'(1) << sel_shift(sel)) - (FINE_W+1)'(1);
        return t[FINE_W-1:0];
    endfunction

    // Absolute tick position of a (loop, fine) pair.
    function automatic pos_t tick_pos(input loop_t lp, input fine_t fn,
                                      input logic [SEL_W-1:0] sel);
        return (POS_W'(lp) << sel_shift(sel)) | POS_W'(fn);
    endfunction

    // Tick position at which the output falls.
    function automatic pos_t fall_pos(input pwm_cfg_t c);
        return tick_pos(c.cmp_loop, c.cmp_fine & fine_last(c.sel), c.sel);
    endfunction

endpackage

// File: rtl/hrpwm_shadow.sv
module hrpwm_shadow
    import hrpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  pwm_cfg_t cfg_in,
    output pwm_cfg_t cfg_q,
    output pwm_cfg_t cfg_d
);

    // Next active configuration: the inputs on a period start, else hold.
    always_comb begin
        cfg_d = load ? cfg_in : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/hrpwm_timebase.sv
module hrpwm_timebase
    import hrpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] act_sel,
    input  loop_t            act_max,
    output fine_t            fine_q,
    output loop_t            loop_q,
    output logic             run_q,
    output fine_t            fine_d,
    output loop_t            loop_d,
    output logic             load,
    output logic             wrap
);

    fine_t fine_end;
    logic  at_last;
    logic  start;
    logic  run_d;

    always_comb begin
        fine_end = fine_last(act_sel);
        at_last  = run_q && (fine_q == fine_end) && (loop_q == act_max);
        start    = en && !run_q;
        wrap     = en && at_last;
        load     = start || wrap;
    end

    always_comb begin
        if (!en) begin
            fine_d = '0;
            loop_d = '0;
            run_d  = 1'b0;
        end else if (load) begin
            fine_d = '0;
            loop_d = '0;
            run_d  = 1'b1;
        end else if (fine_q == fine_end) begin
            fine_d = '0;
            loop_d = loop_q + loop_t'(1);
            run_d  = 1'b1;
        end else begin
            fine_d = fine_q + fine_t'(1);
            loop_d = loop_q;
            run_d  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q <= '0;
            loop_q <= '0;
            run_q  <= 1'b0;
        end else begin
            fine_q <= fine_d;
            loop_q <= loop_d;
            run_q  <= run_d;
        end
    end

    // The loop counter never passes the active maximum.
    p_loop_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (loop_q <= act_max));

    // The fine counter stays inside the selected loop length.
    p_fine_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (fine_q <= fine_last(act_sel)));

endmodule

// File: rtl/hrpwm_edge.sv
module hrpwm_edge
    import hrpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  pwm_cfg_t cfg_d,
    input  fine_t    fine_d,
    input  loop_t    loop_d,
    input  logic     wrap,
    input  fine_t    fine_q,
    input  loop_t    loop_q,
    output logic     pwm_q,
    output logic     end_q
);

    logic level_d;

    // The output is high while the next tick position is below the edge.
    always_comb begin
        level_d = en && (tick_pos(loop_d, fine_d, cfg_d.sel) < fall_pos(cfg_d));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
            end_q <= 1'b0;
        end else begin
            pwm_q <= level_d;
            end_q <= wrap;
        end
    end

    p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
        end_q |=> !end_q);

    p_strobe_at_origin_r2: assert property (@(posedge clk) disable iff (rst)
        end_q |-> (fine_q == '0 && loop_q == '0));

    p_rise_at_origin_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> (fine_q == '0 && loop_q == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm_q && !end_q));

endmodule

// File: rtl/hrpwm_core.sv
module hrpwm_core
    import hrpwm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [SEL_W-1:0]      pre_sel,
    input  logic [LOOP_W-1:0]     per_max,
    input  logic [LOOP_W-1:0]     cmp_loop,
    input  logic [FINE_W-1:0]     cmp_fine,
    output logic                  pwm_o,
    output logic                  period_end_o
);

    pwm_cfg_t cfg_in;
    pwm_cfg_t cfg_q;
    pwm_cfg_t cfg_d;
    fine_t    fine_q;
    fine_t    fine_d;
    loop_t    loop_q;
    loop_t    loop_d;
    logic     run_q;
    logic     load;
    logic     wrap;

    always_comb begin
        cfg_in.sel      = pre_sel;
        cfg_in.per_max  = per_max;
        cfg_in.cmp_loop = cmp_loop;
        cfg_in.cmp_fine = cmp_fine;
    end

    hrpwm_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .cfg_d  (cfg_d)
    );

    hrpwm_timebase u_timebase (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .act_sel (cfg_q.sel),
        .act_max (cfg_q.per_max),
        .fine_q  (fine_q),
        .loop_q  (loop_q),
        .run_q   (run_q),
        .fine_d  (fine_d),
        .loop_d  (loop_d),
        .load    (load),
        .wrap    (wrap)
    );

    hrpwm_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cfg_d  (cfg_d),
        .fine_d (fine_d),
        .loop_d (loop_d),
        .wrap   (wrap),
        .fine_q (fine_q),
        .loop_q (loop_q),
        .pwm_q  (pwm_o),
        .end_q  (period_end_o)
    );

    // Settings stay frozen for the whole of a running period.
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (run_q && en && !wrap) |=> $stable(cfg_q));

endmodule

// File: tb/tb_hrpwm_core.sv
module tb_hrpwm_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] pre_sel  = '0;
    logic [7:0] per_max  = '0;
    logic [7:0] cmp_loop = '0;
    logic [6:0] cmp_fine = '0;
    logic       pwm_o;
    logic       period_end_o;

    always #10 clk = ~clk;

    hrpwm_core dut (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .pre_sel      (pre_sel),
        .per_max      (per_max),
        .cmp_loop     (cmp_loop),
        .cmp_fine     (cmp_fine),
        .pwm_o        (pwm_o),
        .period_end_o (period_end_o)
    );

    typedef struct {
        int    len;
        int    high;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int starts = 0;
    bit done   = 0;

    int  cyc = 0, hi = 0;
    bit  open = 0, was_run = 0, prev_end = 0;
    int  idle_err = 0, dbl_err = 0, first_err = 0, empty_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures each period and compares with the scoreboard.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (!en) begin
                if (open) begin
                    if (q.size() > 0) void'(q.pop_front());
                    open = 0;
                end
                if (pwm_o || period_end_o) idle_err++;
                was_run = 0;
            end else begin
                bit started;
                started = !was_run;
                was_run = 1;
                if (started && period_end_o) first_err++;
                if (period_end_o && prev_end) dbl_err++;
                if (started || period_end_o) begin
                    if (open) begin
                        if (q.size() == 0) begin
                            empty_err++;
                        end else begin
                            exp_t e;
                            e = q.pop_front();
                            check(cyc == e.len, {"R2 period length ", e.tag}, cyc, e.len);
                            check(hi == e.high, {"R4 high count ", e.tag}, hi, e.high);
                        end
                    end
                    open = 1;
                    cyc = 0;
                    hi = 0;
                    starts++;
                end
                cyc++;
                if (pwm_o) hi++;
            end
            prev_end = period_end_o;
        end
    end

    // Driver: pushes expected items, applies settings, waits n period starts.
    task automatic run_cfg(input int sel, input int pm, input int lp, input int fn,
                           input int n, input string tag);
        int p, len, edge_t, tgt;
        exp_t e;
        p = (sel == 0) ? 5 : (sel == 1) ? 6 : 7;
        len = (pm + 1) << p;
        edge_t = (lp << p) + (fn & ((1 << p) - 1));
        e.len = len;
        e.high = (edge_t < len) ? edge_t : len;
        e.tag = tag;
        for (int i = 0; i < n; i++) q.push_back(e);
        pre_sel  = 2'(sel);
        per_max  = 8'(pm);
        cmp_loop = 8'(lp);
        cmp_fine = 7'(fn);
        tgt = starts + n;
        en = 1'b1;
        while (starts < tgt) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
        check(period_end_o == 1'b0, "R1 strobe in reset", int'(period_end_o), 0);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R4: plain duty, 32-tick loops: 1*32 + 7 = 39 of 128
        run_cfg(0, 3, 1, 7, 3, "R4 sel0");
        // R5: zero compare; R8: applied mid-period, effective next period
        run_cfg(1, 2, 0, 0, 2, "R5 R8 zero duty");
        // R2: 4096-tick period, 128-tick loops, half duty
        run_cfg(2, 31, 16, 0, 2, "R2 R3 sel2 4096");
        // R6 and R3 code 3: loop compare past maximum, 128-tick loops
        run_cfg(3, 1, 5, 3, 2, "R6 R3 sel3 full");
        // R7: upper fine bits ignored, 0x65 & 31 = 5 -> 69
        run_cfg(0, 4, 2, 'h65, 2, "R7 fine mask");
        // R4 edge on the last tick, same cycle as the wrap
        run_cfg(1, 0, 0, 63, 3, "R4 last tick");
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(pwm_o == 1'b0, "R9 pwm after disable", int'(pwm_o), 0);
        check(period_end_o == 1'b0, "R9 strobe after disable", int'(period_end_o), 0);
        repeat (300) @(negedge clk);
        #1;
        // R9: restart from idle with current inputs
        run_cfg(0, 3, 1, 7, 2, "R9 restart");
        en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        done = 1;
        check(idle_err == 0, "R9 activity while disabled", idle_err, 0);
        check(first_err == 0, "R9 strobe on first period", first_err, 0);
        check(dbl_err == 0, "R10 strobe two cycles", dbl_err, 0);
        check(empty_err == 0, "R2 unexpected period", empty_err, 0);
        check(q.size() == 0, "R2 periods missing", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule